// File: doc/BRIEF.md
# Edge-Selectable Serial Command Receiver with Chained Output

This block is the digital receiver of a serial-controlled converter. It takes 16-bit command words from a three-wire link (serial clock, active-low select, data in) and drives a serial data output. The three link lines are asynchronous to the block. Each one passes through a synchronizer, and the block finds serial-clock edges by oversampling them with a system clock at least four times faster than the serial clock. While select is low, each rising serial-clock edge shifts one data bit into a shift register, most significant bit first. When select goes high, the block hands the last full word it received to the command decoder, together with a one-cycle strobe.

The serial output is taken from the far end of the same shift register, so several devices can be chained by wiring each output to the next device's data input. A mode input picks the serial-clock edge that updates the output. With the falling edge, a bit leaves the chain half a serial clock after it reaches the last stage, which gives the usual 16-clock pass-through. With the rising edge, the output follows the last stage at once, and a bit appears half a clock sooner. The command logic that owns the mode resets it to falling-edge operation.

Top module: `sdac_serial_front`

## Requirements
- R1: While select (`csn_i`) is high, serial-clock edges change neither the shift register nor the output. `sdo_o`, `word_o` and `word_vld_o` keep their values, and later frames behave as if those edges had never occurred.
- R2: While select is low, each rising `sclk_i` edge shifts `sdi_i` into the register, most significant bit first. After exactly 16 bits, `word_o` bit 15 holds the first bit received and bit 0 holds the last.
- R3: A rise of select after at least 16 bits in the frame raises `word_vld_o` for exactly one system-clock cycle. `word_o` takes the captured word in that cycle and holds it until the next strobe.
- R4: A rise of select after fewer than 16 bits produces no strobe, and `word_o` keeps its previous value.
- R5: A frame longer than 16 bits delivers the last 16 bits received, with the oldest of them in bit 15.
- R6: With `edge_mode_i` = 0, `sdo_o` changes only on falling serial-clock edges. After the falling edge that follows the Nth shift, it equals the bit shifted 15 shifts earlier. The shift count runs continuously across frames, and reset loads zeros.
- R7: With `edge_mode_i` = 1, `sdo_o` changes on rising serial-clock edges. Right after the Nth shift, it equals the bit shifted 15 shifts earlier, half a serial clock sooner than in R6.
- R8: A fall of select clears `sdo_o` to 0 and restarts the bit count. `sdo_o` holds its value from a rise of select until the next fall of select.
- R9: After reset, `word_o` is 0, `word_vld_o` is 0 and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous, idles low |
| csn_i | input | 1 | Active-low select, asynchronous |
| sdi_i | input | 1 | Serial data in, sampled on rising `sclk_i` |
| edge_mode_i | input | 1 | 0: output updates on falling edges, 1: on rising edges |
| word_o | output | 16 | Last captured command word |
| word_vld_o | output | 1 | One-cycle strobe when a new word is presented |
| sdo_o | output | 1 | Serial data out for chaining and readback |

## Verification
The bench sweeps both output modes over frame lengths below, at and above 16 bits. The most telling cases are 15 bits and 17 bits. A design with an off-by-one counter would strobe on the short frame, and a design that keeps the first 16 bits instead of the last would deliver the wrong word on the long one. Frames run back to back, so the stale bits from earlier frames reach the output. A design that cleared the shift register on select, or launched the post-shift bit on the wrong edge, would show a value half a clock early or late. Serial-clock pulses sent while select is high would corrupt the output and the next frame in a design that failed to gate them.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

   typedef enum logic {
      SDO_ON_FALL = 1'b0,
      SDO_ON_RISE = 1'b1
   } sdo_edge_e;

   localparam int unsigned SFE_WORD_W_DEF  = 16;
   localparam int unsigned SFE_SYNC_DEF    = 2;
   localparam int unsigned SFE_MIN_SYNC    = 2;

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int unsigned         N_SIG   = 3,
   parameter int unsigned         STAGES  = 2,
   parameter logic [N_SIG-1:0]    RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SIG-1:0] d_i,
   output logic [N_SIG-1:0] q_o
);

   if (STAGES < sfe_pkg::SFE_MIN_SYNC) begin : g_bad_stages
      $error("sfe_sync: STAGES below minimum");
   end

   logic [N_SIG-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[0] <= RST_VAL;
            else         chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain[s] <= RST_VAL;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/sfe_edge.sv
module sfe_edge #(
   parameter int unsigned      N_SIG   = 2,
   parameter logic [N_SIG-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SIG-1:0] lvl_i,
   output logic [N_SIG-1:0] rise_o,
   output logic [N_SIG-1:0] fall_o
);

   logic [N_SIG-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= RST_VAL;
      else         prev_q <= lvl_i;
   end

   for (genvar i = 0; i < N_SIG; i++) begin : g_det
      assign rise_o[i] =  lvl_i[i] & ~prev_q[i];
      assign fall_o[i] = ~lvl_i[i] &  prev_q[i];
   end

endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_active_i,
   input  logic              shift_i,
   input  logic              clear_i,
   input  logic              close_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] shreg_o,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   if (WORD_W < 2) begin : g_bad_width
      $error("sfe_shifter: WORD_W must be at least 2");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] shreg_q;
   logic              do_shift;

   assign do_shift = shift_i & ~clear_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (do_shift && (cnt_q != CNT_FULL)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       shreg_q <= '0;
      else if (do_shift) shreg_q <= {shreg_q[WORD_W-2:0], bit_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_o     <= '0;
         word_vld_o <= 1'b0;
      end else begin
         word_vld_o <= 1'b0;
         if (close_i && (cnt_q == CNT_FULL)) begin
            word_o     <= shreg_q;
            word_vld_o <= 1'b1;
         end
      end
   end

   assign shreg_o = shreg_q;

   AST_NO_SHIFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_active_i |=> $stable(shreg_q)); // R1
   AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_vld_o |=> !word_vld_o); // R3
   AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_FULL); // R4
   AST_SHORT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (close_i && (cnt_q < CNT_FULL)) |=> (!word_vld_o && $stable(word_o))); // R4

endmodule

// File: rtl/sfe_dout.sv
module sfe_dout (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  sfe_pkg::sdo_edge_e  mode_i,
   input  logic                cs_active_i,
   input  logic                clear_i,
   input  logic                sclk_rise_i,
   input  logic                sclk_fall_i,
   input  logic                msb_i,
   input  logic                msb_next_i,
   output logic                sdo_o
);

   import sfe_pkg::*;

   logic launch;
   logic launch_val;

   always_comb begin
      launch     = 1'b0;
      launch_val = msb_i;
      unique case (mode_i)
         SDO_ON_FALL: begin
            launch     = sclk_fall_i & cs_active_i;
            launch_val = msb_i;
         end
         SDO_ON_RISE: begin
            launch     = sclk_rise_i & cs_active_i;
            launch_val = msb_next_i;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sdo_o <= 1'b0;
      else if (clear_i) sdo_o <= 1'b0;
      else if (launch)  sdo_o <= launch_val;
   end

   AST_CS_FALL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (sdo_o == 1'b0)); // R8
   AST_SDO_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cs_active_i |=> $stable(sdo_o)); // R8
   AST_RISE_MODE_FALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == SDO_ON_RISE) && sclk_fall_i && !clear_i) |=> $stable(sdo_o)); // R7
   AST_FALL_MODE_RISE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == SDO_ON_FALL) && sclk_rise_i && !clear_i) |=> $stable(sdo_o)); // R6

endmodule

// File: rtl/sdac_serial_front.sv
module sdac_serial_front #(
   parameter int unsigned WORD_W      = sfe_pkg::SFE_WORD_W_DEF,
   parameter int unsigned SYNC_STAGES = sfe_pkg::SFE_SYNC_DEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_i,
   input  logic              csn_i,
   input  logic              sdi_i,
   input  logic              edge_mode_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              sdo_o
);

   import sfe_pkg::*;

   localparam int unsigned N_IN   = 3;
   localparam int unsigned IX_SCK = 0;
   localparam int unsigned IX_CSN = 1;
   localparam int unsigned IX_SDI = 2;
   localparam logic [N_IN-1:0] IN_RST = N_IN'(1) << IX_CSN;

   if (WORD_W < 2) begin : g_bad_word
      $error("sdac_serial_front: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < SFE_MIN_SYNC) begin : g_bad_sync
      $error("sdac_serial_front: SYNC_STAGES below minimum");
   end

   logic [N_IN-1:0]   raw_in, syn_in;
   logic [1:0]        ed_rise, ed_fall;
   logic              sck_rise, sck_fall, cs_open, cs_close, cs_active;
   logic [WORD_W-1:0] shreg;
   sdo_edge_e         mode;

   assign raw_in[IX_SCK] = sclk_i;
   assign raw_in[IX_CSN] = csn_i;
   assign raw_in[IX_SDI] = sdi_i;

   sfe_sync #(
      .N_SIG   (N_IN),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_RST)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in),
      .q_o    (syn_in)
   );

   sfe_edge #(
      .N_SIG   (2),
      .RST_VAL (2'b10)
   ) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  ({syn_in[IX_CSN], syn_in[IX_SCK]}),
      .rise_o (ed_rise),
      .fall_o (ed_fall)
   );

   assign sck_rise  = ed_rise[0];
   assign sck_fall  = ed_fall[0];
   assign cs_close  = ed_rise[1];
   assign cs_open   = ed_fall[1];
   assign cs_active = ~syn_in[IX_CSN];
   assign mode      = sdo_edge_e'(edge_mode_i);

   sfe_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cs_active_i (cs_active),
      .shift_i     (sck_rise & cs_active),
      .clear_i     (cs_open),
      .close_i     (cs_close),
      .bit_i       (syn_in[IX_SDI]),
      .shreg_o     (shreg),
      .word_o      (word_o),
      .word_vld_o  (word_vld_o)
   );

   sfe_dout u_dout (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode),
      .cs_active_i (cs_active),
      .clear_i     (cs_open),
      .sclk_rise_i (sck_rise),
      .sclk_fall_i (sck_fall),
      .msb_i       (shreg[WORD_W-1]),
      .msb_next_i  (shreg[WORD_W-2]),
      .sdo_o       (sdo_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(word_vld_o) |-> $past(cs_close)); // R3

endmodule

// File: tb/sdac_serial_front_tb_top.sv
module sdac_serial_front_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        csn = 1'b1;
   logic        sdi = 1'b0;
   logic        mode = 1'b0;
   logic [15:0] word;
   logic        vld;
   logic        sdo;

   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;
   logic [15:0] hist = '0;
   logic [15:0] last_word = '0;
   logic        sdo_exp = 1'b0;

   always #4 clk = ~clk;

   sdac_serial_front dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sclk_i      (sclk),
      .csn_i       (csn),
      .sdi_i       (sdi),
      .edge_mode_i (mode),
      .word_o      (word),
      .word_vld_o  (vld),
      .sdo_o       (sdo)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      sdi = b;
      tick(4);
      sclk = 1'b1;
      hist = {hist[14:0], b};
      tick(4);
      if (mode) begin
         sdo_exp = hist[15];
         chk("R7 sdo after rise", sdo, sdo_exp);
      end else begin
         chk("R6 sdo steady after rise", sdo, sdo_exp);
      end
      sclk = 1'b0;
      tick(4);
      if (!mode) begin
         sdo_exp = hist[15];
         chk("R6 sdo after fall", sdo, sdo_exp);
      end else begin
         chk("R7 sdo steady after fall", sdo, sdo_exp);
      end
   endtask

   task automatic frame(input logic [31:0] pat, input int n);
      int pulses;
      string tag;
      csn = 1'b0;
      tick(6);
      sdo_exp = 1'b0;
      chk("R8 sdo cleared on select fall", sdo, 1'b0);
      for (int i = 0; i < n; i++) shift_bit(pat[n-1-i]);
      tick(4);
      csn = 1'b1;
      pulses = 0;
      for (int c = 0; c < 8; c++) begin
         tick(1);
         if (vld) pulses++;
      end
      if (n >= 16) last_word = hist;
      tag = (n > 16) ? "R5 last 16 bits" : (n == 16) ? "R2 word" : "R4 short frame word";
      chk((n >= 16) ? "R3 strobe count" : "R4 no strobe", pulses, (n >= 16) ? 1 : 0);
      chk(tag, word, last_word);
      chk("R8 sdo holds after select rise", sdo, sdo_exp);
   endtask

   task automatic idle_toggles(input int k);
      for (int i = 0; i < k; i++) begin
         sdi = ~sdi;
         tick(4);
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
      end
      tick(6);
      chk("R1 sdo with select high", sdo, sdo_exp);
      chk("R1 word with select high", word, last_word);
      chk("R1 no strobe with select high", vld, 1'b0);
   endtask

   initial begin
      int lens [7] = '{1, 5, 15, 16, 17, 24, 32};
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk("R9 reset word", word, 16'h0000);
      chk("R9 reset strobe", vld, 1'b0);
      chk("R9 reset sdo", sdo, 1'b0);

      for (int m = 0; m < 2; m++) begin
         mode = m[0];
         tick(2);
         for (int li = 0; li < 7; li++) begin
            for (int p = 0; p < 6; p++) begin
               logic [31:0] pat;
               pat = (32'(li * 6 + p + m * 64) * 32'h9E3779B1) ^ (32'(p) << 7);
               frame(pat, lens[li]);
               if (p == 2) idle_toggles(3);
            end
         end
         for (int v = 0; v < 16; v++) begin
            logic [31:0] pat;
            pat = (32'h1 << v) ^ (m[0] ? 32'hFFFF : 32'h0);
            frame(pat, 16);
         end
         frame(32'h0000FFFF, 16);
         frame(32'h00000000, 16);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule